// File: doc/BRIEF.md
# Packed Variable-Length Instruction Decoder

This block turns a byte stream into decoded instruction records. Bytes arrive one per cycle from a fetch buffer over a valid/ready handshake. The first byte of each instruction is the opcode. A fixed table maps the opcode to an operand format class, which sets how many register bytes and immediate bytes follow. The operands are packed back to back with no padding. Instructions are 1 to 11 bytes long.

When the last byte of an instruction arrives, the block presents one record. The record holds the opcode, the format class, up to four register indices and a 64-bit immediate. The immediate is assembled byte by byte, least significant byte first. The record is held until downstream takes it, and no new bytes are accepted while it waits.

An unknown opcode or an out-of-range register byte raises a trap that carries the offending byte. After a trap, the decoder consumes and discards every further byte until a synchronous restart.

Top module: `vlen_insn_decoder`

## Requirements
- R1: The format class comes from the opcode as follows (out_fmt code in brackets):
  - N [0]: opcodes 0 and 45, no operand bytes.
  - RR [1]: opcodes 13, 14 and 28, two register bytes.
  - RRR [2]: opcodes 1–11, 46 and 47, three register bytes.
  - RRRR [3]: opcodes 12 and 48, four register bytes.
  - RI [4]: opcodes 29 and 38, one register byte, then eight immediate bytes.
  - RRI [5]: opcodes 18–27, 30–37, 39–44, 49 and 50, two register bytes, then eight immediate bytes.
  
  A record appears exactly after the opcode byte plus that many operand bytes, with out_opcode equal to the opcode byte.
- R2: Register operand bytes fill out_regs slot 0, 1, 2, 3 in arrival order. Slot k is out_regs[8k+7:8k]. Slots the format does not use read zero.
- R3: The first immediate byte lands in out_imm[7:0] and each following byte lands 8 bits higher. out_imm is zero for formats without an immediate.
- R4: out_valid rises in the cycle after the last byte of an instruction is accepted. The record stays unchanged until a cycle with out_ready high, after which out_valid falls.
- R5: in_ready is low exactly while a record is pending, so bytes are accepted only when in_valid and in_ready are both high.
- R6: An opcode outside the assigned set (for example 15–17 and 51–255) sets trap_valid in the next cycle, with trap_cause 1 and trap_param equal to the opcode byte.
- R7: A register operand byte above 59 sets trap_valid in the next cycle, with trap_cause 2 and trap_param equal to that byte. A register byte of 59 is accepted.
- R8: After a trap, no record is emitted. Incoming bytes are still accepted and discarded. trap_valid, trap_cause and trap_param hold until restart.
- R9: A restart cycle clears the trap, drops any pending record or partial instruction, and makes the next accepted byte an opcode.
- R10: After reset, out_valid and trap_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous restart of decoding |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Decoded record pending |
| out_ready | input | 1 | Downstream takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_fmt | output | 3 | Format class code |
| out_regs | output | 32 | Four register slots, 8 bits each |
| out_imm | output | 64 | Immediate value |
| trap_valid | output | 1 | Trap raised, sticky |
| trap_cause | output | 2 | 1 bad opcode, 2 bad register |
| trap_param | output | 8 | Offending byte |

## Verification
The assertions assume that restart is a clean single-cycle command that outranks every other event. They also assume that out_ready is only meaningful while out_valid is high, so a dropped record shows up only through a restart. The stimulus pulses restart only between traffic phases, except in one case where it deliberately cancels a pending record. Register bytes are drawn from 0 to 59 except in the directed trap cases. The valid and ready inputs toggle at random rates, so records are held across many stalled cycles and bytes arrive both back to back and with gaps.

// File: rtl/vlid_pkg.sv
package vlid_pkg;

  typedef enum logic [2:0] {
    FMT_N    = 3'd0,
    FMT_RR   = 3'd1,
    FMT_RRR  = 3'd2,
    FMT_RRRR = 3'd3,
    FMT_RI   = 3'd4,
    FMT_RRI  = 3'd5,
    FMT_I    = 3'd6
  } fmt_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_OPCODE = 2'd1,
    CAUSE_REG    = 2'd2
  } cause_e;

  typedef struct packed {
    logic ok;
    fmt_e fmt;
  } op_class_t;

  // Opcode to operand class; ok low for unassigned opcodes.
  function automatic op_class_t classify(input logic [7:0] op);
    op_class_t c;
    c.ok  = 1'b1;
    c.fmt = FMT_N;
    if (op == 8'd0 || op == 8'd45)
      c.fmt = FMT_N;
    else if ((op >= 8'd1 && op <= 8'd11) || op == 8'd46 || op == 8'd47)
      c.fmt = FMT_RRR;
    else if (op == 8'd12 || op == 8'd48)
      c.fmt = FMT_RRRR;
    else if (op == 8'd13 || op == 8'd14 || op == 8'd28)
      c.fmt = FMT_RR;
    else if (op == 8'd29 || op == 8'd38)
      c.fmt = FMT_RI;
    else if ((op >= 8'd18 && op <= 8'd27) || (op >= 8'd30 && op <= 8'd37) ||
             (op >= 8'd39 && op <= 8'd44) || op == 8'd49 || op == 8'd50)
      c.fmt = FMT_RRI;
    else
      c.ok = 1'b0;
    return c;
  endfunction

  // Number of register bytes carried by a class.
  function automatic logic [2:0] fmt_regs(input fmt_e f);
    logic [2:0] n;
    case (f)
      FMT_RR:   n = 3'd2;
      FMT_RRR:  n = 3'd3;
      FMT_RRRR: n = 3'd4;
      FMT_RI:   n = 3'd1;
      FMT_RRI:  n = 3'd2;
      default:  n = 3'd0;
    endcase
    return n;
  endfunction

  // Whether the class ends with an immediate field.
  function automatic logic fmt_has_imm(input fmt_e f);
    return (f == FMT_RI) || (f == FMT_RRI) || (f == FMT_I);
  endfunction

endpackage

// File: rtl/vlid_format_lut.sv
module vlid_format_lut
  import vlid_pkg::*;
#(
  parameter int unsigned IMM_BYTES = 8,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [7:0]       opcode,
  output logic             ok,
  output fmt_e             fmt,
  output logic [LEN_W-1:0] nregs,
  output logic [LEN_W-1:0] len
);

  op_class_t cls;

  always_comb begin
    cls   = classify(opcode);
    ok    = cls.ok;
    fmt   = cls.fmt;
    nregs = LEN_W'(fmt_regs(cls.fmt));
    len   = nregs + (fmt_has_imm(cls.fmt) ? LEN_W'(IMM_BYTES) : '0);
  end

endmodule

// File: rtl/vlid_operand_store.sv
module vlid_operand_store #(
  parameter int unsigned REG_SLOTS = 4,
  parameter int unsigned IMM_BYTES = 8,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   reg_we,
  input  logic [SLOT_W-1:0]      reg_idx,
  input  logic                   imm_we,
  input  logic [IDX_W-1:0]       imm_idx,
  input  logic [7:0]             din,
  output logic [REG_SLOTS*8-1:0] regs_flat,
  output logic [IMM_BYTES*8-1:0] imm_flat
);

  for (genvar s = 0; s < REG_SLOTS; s++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (clear)                              q <= '0;
      else if (reg_we && reg_idx == SLOT_W'(s))    q <= din;
    end
    assign regs_flat[s*8 +: 8] = q;
  end

  for (genvar b = 0; b < IMM_BYTES; b++) begin : g_imm
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (clear)                              q <= '0;
      else if (imm_we && imm_idx == IDX_W'(b))     q <= din;
    end
    assign imm_flat[b*8 +: 8] = q;
  end

endmodule

// File: rtl/vlid_seq.sv
module vlid_seq
  import vlid_pkg::*;
#(
  parameter int unsigned REG_COUNT = 60,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_opcode,
  output logic [2:0]       out_fmt,
  output logic             trap_valid,
  output logic [1:0]       trap_cause,
  output logic [7:0]       trap_param,
  input  logic             lut_ok,
  input  fmt_e             lut_fmt,
  input  logic [LEN_W-1:0] lut_nregs,
  input  logic [LEN_W-1:0] lut_len,
  output logic             store_clear,
  output logic             reg_we,
  output logic [SLOT_W-1:0] reg_idx,
  output logic             imm_we,
  output logic [IDX_W-1:0] imm_idx,
  output logic             ev_bad_op,
  output logic             ev_bad_reg,
  output logic             ev_done
);

  localparam logic [7:0] REG_MAX = 8'(REG_COUNT - 1);

  typedef enum logic [1:0] {S_OPC, S_OPR, S_HALT} state_e;

  state_e           state_q;
  logic [LEN_W-1:0] cnt_q, nregs_q, len_q;
  logic             out_valid_q;
  logic             accept, take_opc, take_opr, in_reg_pos;

  assign in_ready   = !out_valid_q;
  assign out_valid  = out_valid_q;
  assign accept     = in_valid && in_ready;
  assign take_opc   = accept && (state_q == S_OPC);
  assign take_opr   = accept && (state_q == S_OPR);
  assign in_reg_pos = cnt_q < nregs_q;

  assign ev_bad_op  = take_opc && !lut_ok;
  assign ev_bad_reg = take_opr && in_reg_pos && (in_byte > REG_MAX);
  assign ev_done    = (take_opc && lut_ok && lut_len == '0) ||
                      (take_opr && !ev_bad_reg && cnt_q == len_q - LEN_W'(1));

  assign store_clear = take_opc && lut_ok;
  assign reg_we      = take_opr && in_reg_pos && !ev_bad_reg;
  assign reg_idx     = SLOT_W'(cnt_q);
  assign imm_we      = take_opr && !in_reg_pos;
  assign imm_idx     = IDX_W'(cnt_q - nregs_q);

  // Sequencing of opcode and operand bytes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OPC;
      cnt_q   <= '0;
      nregs_q <= '0;
      len_q   <= '0;
    end else if (restart) begin
      state_q <= S_OPC;
      cnt_q   <= '0;
    end else if (ev_bad_op || ev_bad_reg) begin
      state_q <= S_HALT;
    end else if (ev_done) begin
      state_q <= S_OPC;
      cnt_q   <= '0;
    end else if (take_opc) begin
      state_q <= S_OPR;
      cnt_q   <= '0;
      nregs_q <= lut_nregs;
      len_q   <= lut_len;
    end else if (take_opr) begin
      cnt_q   <= cnt_q + LEN_W'(1);
    end
  end

  // Record header and handshake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_opcode  <= '0;
      out_fmt     <= '0;
    end else if (restart) begin
      out_valid_q <= 1'b0;
    end else begin
      if (take_opc && lut_ok) begin
        out_opcode <= in_byte;
        out_fmt    <= lut_fmt;
      end
      if (ev_done)
        out_valid_q <= 1'b1;
      else if (out_ready)
        out_valid_q <= 1'b0;
    end
  end

  // Sticky trap report.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_cause <= CAUSE_NONE;
      trap_param <= '0;
    end else if (restart) begin
      trap_valid <= 1'b0;
      trap_cause <= CAUSE_NONE;
      trap_param <= '0;
    end else if (ev_bad_op) begin
      trap_valid <= 1'b1;
      trap_cause <= CAUSE_OPCODE;
      trap_param <= in_byte;
    end else if (ev_bad_reg) begin
      trap_valid <= 1'b1;
      trap_cause <= CAUSE_REG;
      trap_param <= in_byte;
    end
  end

endmodule

// File: rtl/vlen_insn_decoder.sv
module vlen_insn_decoder
  import vlid_pkg::*;
#(
  parameter int unsigned REG_SLOTS = 4,
  parameter int unsigned IMM_BYTES = 8,
  parameter int unsigned REG_COUNT = 60
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_byte,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_opcode,
  output logic [2:0]             out_fmt,
  output logic [REG_SLOTS*8-1:0] out_regs,
  output logic [IMM_BYTES*8-1:0] out_imm,
  output logic                   trap_valid,
  output logic [1:0]             trap_cause,
  output logic [7:0]             trap_param
);

  localparam int unsigned LEN_W  = $clog2(REG_SLOTS + IMM_BYTES + 1);
  localparam int unsigned SLOT_W = $clog2(REG_SLOTS);
  localparam int unsigned IDX_W  = $clog2(IMM_BYTES);

  logic             lut_ok;
  fmt_e             lut_fmt;
  logic [LEN_W-1:0] lut_nregs, lut_len;
  logic             store_clear, reg_we, imm_we;
  logic [SLOT_W-1:0] reg_idx;
  logic [IDX_W-1:0] imm_idx;
  logic             ev_bad_op, ev_bad_reg, ev_done;

  vlid_format_lut #(
    .IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)
  ) u_lut (
    .opcode(in_byte), .ok(lut_ok), .fmt(lut_fmt),
    .nregs(lut_nregs), .len(lut_len)
  );

  vlid_seq #(
    .REG_COUNT(REG_COUNT), .LEN_W(LEN_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_opcode(out_opcode), .out_fmt(out_fmt),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_param(trap_param),
    .lut_ok(lut_ok), .lut_fmt(lut_fmt), .lut_nregs(lut_nregs), .lut_len(lut_len),
    .store_clear(store_clear), .reg_we(reg_we), .reg_idx(reg_idx),
    .imm_we(imm_we), .imm_idx(imm_idx),
    .ev_bad_op(ev_bad_op), .ev_bad_reg(ev_bad_reg), .ev_done(ev_done)
  );

  vlid_operand_store #(
    .REG_SLOTS(REG_SLOTS), .IMM_BYTES(IMM_BYTES), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clear(store_clear),
    .reg_we(reg_we), .reg_idx(reg_idx),
    .imm_we(imm_we), .imm_idx(imm_idx),
    .din(in_byte), .regs_flat(out_regs), .imm_flat(out_imm)
  );

endmodule

// File: rtl/vlid_checker.sv
module vlid_checker #(
  parameter int unsigned REG_SLOTS = 4,
  parameter int unsigned IMM_BYTES = 8,
  parameter int unsigned REG_COUNT = 60
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   restart,
  input logic                   in_ready,
  input logic [7:0]             in_byte,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [7:0]             out_opcode,
  input logic [2:0]             out_fmt,
  input logic [REG_SLOTS*8-1:0] out_regs,
  input logic [IMM_BYTES*8-1:0] out_imm,
  input logic                   trap_valid,
  input logic [1:0]             trap_cause,
  input logic [7:0]             trap_param,
  input logic                   ev_bad_op,
  input logic                   ev_bad_reg,
  input logic                   ev_done
);

  logic regs_ok;
  always_comb begin
    regs_ok = 1'b1;
    for (int s = 0; s < REG_SLOTS; s++)
      if (out_regs[s*8 +: 8] > 8'(REG_COUNT - 1)) regs_ok = 1'b0;
  end

  // R4
  done_raises_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !restart |=> out_valid);

  // R4
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !restart |=> out_valid && $stable(out_opcode) &&
    $stable(out_fmt) && $stable(out_regs) && $stable(out_imm));

  // R5
  no_intake_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ev_done && !ev_bad_op && !ev_bad_reg);

  // R6
  bad_opcode_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_op && !restart |=> trap_valid && trap_cause == 2'd1 && trap_param == $past(in_byte));

  // R7
  bad_reg_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_reg && !restart |=> trap_valid && trap_cause == 2'd2 && trap_param == $past(in_byte));

  // R7
  reg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> regs_ok);

  // R8
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !restart |=> trap_valid && $stable(trap_cause) && $stable(trap_param));

  // R8
  trap_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !out_valid && !ev_done);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !trap_valid && !out_valid && in_ready);

endmodule

bind vlen_insn_decoder vlid_checker #(
  .REG_SLOTS(REG_SLOTS), .IMM_BYTES(IMM_BYTES), .REG_COUNT(REG_COUNT)
) u_vlid_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .in_ready(in_ready),
  .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
  .out_opcode(out_opcode), .out_fmt(out_fmt), .out_regs(out_regs),
  .out_imm(out_imm), .trap_valid(trap_valid), .trap_cause(trap_cause),
  .trap_param(trap_param), .ev_bad_op(ev_bad_op), .ev_bad_reg(ev_bad_reg),
  .ev_done(ev_done)
);

// File: tb/test_vlen_insn_decoder.sv
module test_vlen_insn_decoder;

  logic        clk = 1'b0;
  logic        rst_n, restart, in_valid, out_ready;
  logic [7:0]  in_byte;
  logic        in_ready, out_valid, trap_valid;
  logic [7:0]  out_opcode, trap_param;
  logic [2:0]  out_fmt;
  logic [31:0] out_regs;
  logic [63:0] out_imm;
  logic [1:0]  trap_cause;

  vlen_insn_decoder i_vlen_insn_decoder (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_fmt(out_fmt), .out_regs(out_regs), .out_imm(out_imm),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_param(trap_param)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int          stim[$];
  int          cur[$];
  bit          m_halt, m_ov, m_trap;
  logic [7:0]  m_op, m_param;
  logic [2:0]  m_fmt;
  logic [1:0]  m_cause;
  logic [31:0] m_regs;
  logic [63:0] m_imm;
  int          c_code, c_nreg, c_nimm;
  int          vprob = 100, rprob = 100;
  bit          want_restart = 0, was_restart = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // operand layout per opcode: code, register bytes, immediate bytes
  function automatic bit ref_fmt(input int op, output int code, output int nreg, output int nimm);
    code = 0; nreg = 0; nimm = 0;
    if (op inside {0, 45})                          begin code = 0; return 1; end
    if (op inside {13, 14, 28})                     begin code = 1; nreg = 2; return 1; end
    if (op inside {[1:11], 46, 47})                 begin code = 2; nreg = 3; return 1; end
    if (op inside {12, 48})                         begin code = 3; nreg = 4; return 1; end
    if (op inside {29, 38})                         begin code = 4; nreg = 1; nimm = 8; return 1; end
    if (op inside {[18:27], [30:37], [39:44], 49, 50}) begin code = 5; nreg = 2; nimm = 8; return 1; end
    return 0;
  endfunction

  task automatic m_trap_set(input int cause, input int b);
    m_halt = 1; m_trap = 1; m_cause = 2'(cause); m_param = 8'(b); cur.delete();
  endtask

  task automatic m_emit();
    m_ov = 1; m_op = 8'(cur[0]); m_fmt = 3'(c_code); m_regs = '0; m_imm = '0;
    for (int i = 0; i < c_nreg; i++) m_regs[i*8 +: 8] = 8'(cur[1+i]);
    for (int k = 0; k < c_nimm; k++) m_imm = m_imm | (64'(cur[1+c_nreg+k]) << (8*k));
    cur.delete();
  endtask

  task automatic m_byte(input int b);
    cur.push_back(b);
    if (cur.size() == 1) begin
      if (!ref_fmt(b, c_code, c_nreg, c_nimm)) m_trap_set(1, b);
      else if (c_nreg + c_nimm == 0) m_emit();
    end else if (cur.size() - 2 < c_nreg && b > 59) begin
      m_trap_set(2, b);
    end else if (cur.size() == 1 + c_nreg + c_nimm) begin
      m_emit();
    end
  endtask

  task automatic compare();
    check(in_ready == !m_ov, "R5", "in_ready", 64'(in_ready), 64'(!m_ov));
    check(out_valid == m_ov, "R4", "out_valid", 64'(out_valid), 64'(m_ov));
    if (m_ov && out_valid) begin
      check(out_opcode == m_op && out_fmt == m_fmt, "R1", "opcode/fmt",
            {53'd0, out_fmt, out_opcode}, {53'd0, m_fmt, m_op});
      check(out_regs == m_regs, "R2", "regs", 64'(out_regs), 64'(m_regs));
      check(out_imm == m_imm, "R3", "imm", out_imm, m_imm);
    end
    check(trap_valid == m_trap, "R8", "trap_valid", 64'(trap_valid), 64'(m_trap));
    if (m_trap && trap_valid)
      check(trap_cause == m_cause && trap_param == m_param, (m_cause == 2'd1) ? "R6" : "R7",
            "trap cause/param", {54'd0, trap_cause, trap_param}, {54'd0, m_cause, m_param});
    if (was_restart)
      check(!trap_valid && !out_valid && in_ready, "R9", "after restart",
            {61'd0, trap_valid, out_valid, in_ready}, 64'd1);
  endtask

  task automatic cycle();
    bit acc;
    @(negedge clk);
    compare();
    restart   = want_restart;
    was_restart = want_restart;
    want_restart = 0;
    in_valid  = !restart && stim.size() > 0 && ($urandom_range(0, 99) < vprob);
    in_byte   = (stim.size() > 0) ? 8'(stim[0]) : 8'($urandom);
    out_ready = ($urandom_range(0, 99) < rprob);
    #1;
    if (restart) begin
      m_halt = 0; m_ov = 0; m_trap = 0; m_cause = 0; m_param = 0; cur.delete();
    end else begin
      acc = in_valid && !m_ov;
      if (m_ov && out_ready) m_ov = 0;
      if (acc) begin
        void'(stim.pop_front());
        if (!m_halt) m_byte(int'(in_byte));
      end
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 5000 && (stim.size() > 0 || m_ov); n++) cycle();
    cycle(); cycle();
  endtask

  task automatic pulse_restart();
    want_restart = 1; cycle(); cycle();
  endtask

  task automatic push(input int b);
    stim.push_back(b);
  endtask

  task automatic push_rand_insn();
    int op, code, nr, ni;
    do op = $urandom_range(0, 50); while (!ref_fmt(op, code, nr, ni));
    push(op);
    for (int i = 0; i < nr; i++) push($urandom_range(0, 59));
    for (int i = 0; i < ni; i++) push($urandom_range(0, 255));
  endtask

  initial begin
    rst_n = 0; restart = 0; in_valid = 0; out_ready = 0; in_byte = 0;
    m_halt = 0; m_ov = 0; m_trap = 0; m_cause = 0; m_param = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(!out_valid && !trap_valid && in_ready, "R10", "reset state",
          {61'd0, out_valid, trap_valid, in_ready}, 64'd1);

    // one of each class, back to back (R1 R2 R3 R4)
    push(0); push(1); push(3); push(4); push(5);
    push(12); push(1); push(2); push(3); push(4);
    push(13); push(7); push(8);
    push(29); push(9);
    for (int k = 1; k <= 8; k++) push(k * 17);
    push(18); push(59); push(0);
    for (int k = 0; k < 8; k++) push(255 - k);
    push(45);
    drain();

    // same with stalls on both sides
    vprob = 60; rprob = 30;
    for (int i = 0; i < 20; i++) push_rand_insn();
    drain();
    vprob = 100; rprob = 100;

    // R6 unknown opcodes, stream dropped afterwards (R8)
    push(15); push(1); push(2); push(3); push(4); push(0);
    drain(); pulse_restart();
    push(51); push(45); drain(); pulse_restart();
    push(255); push(0); drain(); pulse_restart();
    push(17); drain(); pulse_restart();

    // R7 register out of range, and mid-instruction
    push(18); push(60); push(1); push(2); drain(); pulse_restart();
    push(12); push(1); push(2); push(59); push(200); push(0); drain(); pulse_restart();
    push(3); push(59); push(59); push(59); drain();

    // R9 restart drops a pending record and a partial instruction
    rprob = 0;
    push(13); push(1); push(2);
    for (int n = 0; n < 20 && !m_ov; n++) cycle();
    cycle();
    pulse_restart();
    rprob = 100;
    push(29); push(4); push(1); push(2);
    cycle(); cycle(); cycle(); cycle(); cycle();
    stim.delete();
    pulse_restart();
    push(1); push(10); push(20); push(30);
    drain();

    // random traffic
    for (int i = 0; i < 300; i++) begin
      vprob = $urandom_range(30, 100); rprob = $urandom_range(20, 100);
      push_rand_insn();
      if (i % 10 == 9) drain();
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule